// File: doc/BRIEF.md
# Ones-Count and Parity Prefiltered CAM

This block is a small content-addressable memory of 8 words by 8 bits. A search looks for the stored words that equal a key and returns the address of the best match. A cheap prefilter cuts down the comparison work. When a word is written, the block also stores how many 1 bits the word holds and its XOR parity. When a key is searched, the same two fields are computed for the key. Only valid entries whose count and parity agree with the key's go on to the full bit-by-bit comparison.

The search is split into two pipeline stages. The first stage computes the key fields and registers a per-entry enable vector. The second stage does the full compare on the enabled entries, picks the lowest matching address, and registers the result. A request sampled on one clock edge therefore gives its result after the following edge. Requests may be issued every cycle. A write shares the cycle with a search freely.

Top module: `pfcam_top`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` and marks that entry valid. A later search for that value reports a hit at that address.
- R2: Each entry holds a 4-bit count of its 1 bits (0 to 8) and an XOR parity bit. Only entries whose count and parity both equal the key's pass the first stage. A key whose count agrees with stored words but whose value differs from all of them reports a miss.
- R3: A match line is asserted only for an entry that passed the first stage and whose stored 8 bits equal the key in full.
- R4: A request sampled at clock edge k gives `res_valid_o` high after edge k+1, for one cycle per request. Back-to-back requests produce results in back-to-back cycles.
- R5: On a miss, `res_valid_o` is 1 while `res_hit_o`, `res_addr_o`, `res_lines_o` and `res_onehot_o` are all 0. Outside result cycles, every result output is 0.
- R6: When several entries match, `res_lines_o` has bit i set for every matching entry i. `res_addr_o` is the lowest such i, and `res_onehot_o` has only bit `res_addr_o` set.
- R7: A write issued in the same cycle as a search request is seen by that search. A write issued in the cycle after the request is not seen by it.
- R8: After reset every entry is invalid and all result outputs are 0. A search for key 0x00 then misses, even though the storage holds zeros.
- R9: Rewriting an entry replaces its old word. A search for the old value no longer reports that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Entry to write |
| wr_data_i | input | 8 | Word to store |
| srch_i | input | 1 | Search request |
| srch_key_i | input | 8 | Search key |
| res_valid_o | output | 1 | Result present this cycle |
| res_hit_o | output | 1 | At least one entry matched |
| res_addr_o | output | 3 | Lowest matching entry, 0 on miss |
| res_lines_o | output | 8 | All surviving match lines |
| res_onehot_o | output | 8 | One-hot of the reported entry |

## Verification
The hardest situation to reach from the ports is a write that lands on the same entry a search in flight is using. The first stage filters on fields that a same-cycle write is changing, and the second stage compares data that a write one cycle later is changing. The stimulus places a write exactly in the request cycle, and another exactly in the cycle after it. It expects the first write to be seen and the second to be missed. It then searches for old and new values to confirm that each rewrite took effect.

// File: rtl/pfcam_pkg.sv
package pfcam_pkg;
  parameter int unsigned DEF_ENTRIES = 8;
  parameter int unsigned DEF_WIDTH   = 8;
endpackage

// File: rtl/pfcam_fields.sv
module pfcam_fields #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] cnt_o,
  output logic          par_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(data_i[i]);
  end

  assign par_o = ^data_i;
endmodule

// File: rtl/pfcam_entry.sv
module pfcam_entry #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          par_i,
  output logic          valid_o,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] cnt_o,
  output logic          par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      cnt_o   <= '0;
      par_o   <= 1'b0;
    end else if (we_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      cnt_o   <= cnt_i;
      par_o   <= par_i;
    end
  end

  assert_write_stores_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_o && data_o == $past(data_i) && cnt_o == $past(cnt_i)));
endmodule

// File: rtl/pfcam_prefilter.sv
module pfcam_prefilter #(
  parameter int unsigned E  = 8,
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4,
  parameter int unsigned AW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 srch_i,
  input  logic [W-1:0]         key_i,
  input  logic [CW-1:0]        key_cnt_i,
  input  logic                 key_par_i,
  input  logic [E-1:0]         ent_valid_i,
  input  logic [E-1:0][CW-1:0] ent_cnt_i,
  input  logic [E-1:0]         ent_par_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [CW-1:0]        wr_cnt_i,
  input  logic                 wr_par_i,
  output logic                 s1_valid_o,
  output logic [W-1:0]         s1_key_o,
  output logic [E-1:0]         s1_en_o
);
  logic [E-1:0] byp;
  logic [E-1:0] pass;

  // A same-cycle write overrides the stored fields so the search sees it
  for (genvar i = 0; i < E; i++) begin : g_flt
    logic [CW-1:0] c;
    logic          p;
    assign byp[i]  = wr_en_i && (wr_addr_i == AW'(i));
    assign c       = byp[i] ? wr_cnt_i : ent_cnt_i[i];
    assign p       = byp[i] ? wr_par_i : ent_par_i[i];
    assign pass[i] = (byp[i] | ent_valid_i[i]) && (c == key_cnt_i) && (p == key_par_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_o <= 1'b0;
      s1_key_o   <= '0;
      s1_en_o    <= '0;
    end else begin
      s1_valid_o <= srch_i;
      if (srch_i) begin
        s1_key_o <= key_i;
        s1_en_o  <= pass;
      end else begin
        s1_en_o  <= '0;
      end
    end
  end

  assert_stage1_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_i |=> s1_valid_o);
  assert_only_valid_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_i |=> ((s1_en_o & ~$past(ent_valid_i | byp)) == '0));
endmodule

// File: rtl/pfcam_match.sv
module pfcam_match #(
  parameter int unsigned E  = 8,
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s1_valid_i,
  input  logic [W-1:0]        s1_key_i,
  input  logic [E-1:0]        s1_en_i,
  input  logic [E-1:0][W-1:0] ent_data_i,
  output logic                res_valid_o,
  output logic                res_hit_o,
  output logic [AW-1:0]       res_addr_o,
  output logic [E-1:0]        res_lines_o,
  output logic [E-1:0]        res_onehot_o
);
  logic [E-1:0]  lines;
  logic [E-1:0]  first;
  logic [AW-1:0] idx;

  for (genvar i = 0; i < E; i++) begin : g_cmp
    assign lines[i] = s1_en_i[i] && (ent_data_i[i] == s1_key_i);
  end

  always_comb begin
    idx = '0;
    for (int i = E - 1; i >= 0; i--) if (lines[i]) idx = AW'(i);
  end

  assign first = lines & (~lines + E'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_addr_o   <= '0;
      res_lines_o  <= '0;
      res_onehot_o <= '0;
    end else begin
      res_valid_o  <= s1_valid_i;
      res_hit_o    <= s1_valid_i && (lines != '0);
      res_addr_o   <= s1_valid_i ? idx : '0;
      res_lines_o  <= s1_valid_i ? lines : '0;
      res_onehot_o <= s1_valid_i ? first : '0;
    end
  end

  assert_result_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_i |=> res_valid_o);
  assert_no_spurious_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_i |=> !res_valid_o);
  assert_lines_filtered_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_i |=> ((res_lines_o & ~$past(s1_en_i)) == '0));
  assert_miss_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_addr_o == '0 && res_onehot_o == '0 && res_lines_o == '0));
  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res_onehot_o));
  assert_lowest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> (res_onehot_o != '0 && (res_onehot_o & res_lines_o) == res_onehot_o
                   && (res_lines_o & (res_onehot_o - E'(1))) == '0));
endmodule

// File: rtl/pfcam_top.sv
module pfcam_top #(
  parameter int unsigned ENTRIES = pfcam_pkg::DEF_ENTRIES,
  parameter int unsigned WIDTH   = pfcam_pkg::DEF_WIDTH,
  localparam int unsigned CW = $clog2(WIDTH + 1),
  localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [WIDTH-1:0]   wr_data_i,
  input  logic               srch_i,
  input  logic [WIDTH-1:0]   srch_key_i,
  output logic               res_valid_o,
  output logic               res_hit_o,
  output logic [AW-1:0]      res_addr_o,
  output logic [ENTRIES-1:0] res_lines_o,
  output logic [ENTRIES-1:0] res_onehot_o
);
  logic [CW-1:0] wr_cnt, key_cnt;
  logic          wr_par, key_par;

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][WIDTH-1:0] ent_data;
  logic [ENTRIES-1:0][CW-1:0]    ent_cnt;
  logic [ENTRIES-1:0]            ent_par;

  logic               s1_valid;
  logic [WIDTH-1:0]   s1_key;
  logic [ENTRIES-1:0] s1_en;

  pfcam_fields #(.W(WIDTH), .CW(CW)) u_wr_fields (
    .data_i(wr_data_i), .cnt_o(wr_cnt), .par_o(wr_par));

  pfcam_fields #(.W(WIDTH), .CW(CW)) u_key_fields (
    .data_i(srch_key_i), .cnt_o(key_cnt), .par_o(key_par));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    pfcam_entry #(.W(WIDTH), .CW(CW)) u_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_addr_i == AW'(i))),
      .data_i  (wr_data_i),
      .cnt_i   (wr_cnt),
      .par_i   (wr_par),
      .valid_o (ent_valid[i]),
      .data_o  (ent_data[i]),
      .cnt_o   (ent_cnt[i]),
      .par_o   (ent_par[i])
    );
  end

  pfcam_prefilter #(.E(ENTRIES), .W(WIDTH), .CW(CW), .AW(AW)) u_prefilter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srch_i      (srch_i),
    .key_i       (srch_key_i),
    .key_cnt_i   (key_cnt),
    .key_par_i   (key_par),
    .ent_valid_i (ent_valid),
    .ent_cnt_i   (ent_cnt),
    .ent_par_i   (ent_par),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_cnt_i    (wr_cnt),
    .wr_par_i    (wr_par),
    .s1_valid_o  (s1_valid),
    .s1_key_o    (s1_key),
    .s1_en_o     (s1_en)
  );

  pfcam_match #(.E(ENTRIES), .W(WIDTH), .AW(AW)) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .s1_valid_i   (s1_valid),
    .s1_key_i     (s1_key),
    .s1_en_i      (s1_en),
    .ent_data_i   (ent_data),
    .res_valid_o  (res_valid_o),
    .res_hit_o    (res_hit_o),
    .res_addr_o   (res_addr_o),
    .res_lines_o  (res_lines_o),
    .res_onehot_o (res_onehot_o)
  );
endmodule

// File: tb/pfcam_top_tb.sv
module pfcam_top_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       srch_i = 1'b0;
  logic [7:0] srch_key_i = '0;
  logic       res_valid_o, res_hit_o;
  logic [2:0] res_addr_o;
  logic [7:0] res_lines_o, res_onehot_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  pfcam_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .srch_i(srch_i), .srch_key_i(srch_key_i),
    .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_addr_o(res_addr_o),
    .res_lines_o(res_lines_o), .res_onehot_o(res_onehot_o));

  typedef struct packed {
    logic [7:0] key;
    logic       hit;
    logic [2:0] addr;
    logic [7:0] lines;
  } vec_t;

  // contents: 3C A5 3C 0F FF 00 81 5A
  localparam vec_t VECS [10] = '{
    '{8'h3C, 1'b1, 3'd0, 8'h05},
    '{8'hA5, 1'b1, 3'd1, 8'h02},
    '{8'h0F, 1'b1, 3'd3, 8'h08},
    '{8'hFF, 1'b1, 3'd4, 8'h10},
    '{8'h00, 1'b1, 3'd5, 8'h20},
    '{8'h81, 1'b1, 3'd6, 8'h40},
    '{8'h5A, 1'b1, 3'd7, 8'h80},
    '{8'hC3, 1'b0, 3'd0, 8'h00},
    '{8'h01, 1'b0, 3'd0, 8'h00},
    '{8'h7F, 1'b0, 3'd0, 8'h00}
  };

  task automatic chk_res(string tag, logic hit, logic [2:0] addr, logic [7:0] lines);
    logic [20:0] act, exp;
    act = {res_valid_o, res_hit_o, res_addr_o, res_lines_o, res_onehot_o};
    exp = {1'b1, hit, addr, lines, hit ? (8'd1 << addr) : 8'd0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,hit,addr,lines,onehot} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(string tag);
    logic [20:0] act;
    act = {res_valid_o, res_hit_o, res_addr_o, res_lines_o, res_onehot_o};
    checks++;
    if (act !== '0) begin
      errors++;
      $display("FAIL %s: result outputs actual=%h expected=0", tag, act);
    end
  endtask

  task automatic write(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic search(string tag, logic [7:0] k, logic hit, logic [2:0] addr, logic [7:0] lines);
    @(negedge clk_i);
    srch_i = 1'b1; srch_key_i = k;
    @(negedge clk_i);
    srch_i = 1'b0;
    @(negedge clk_i);
    chk_res(tag, hit, addr, lines);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R8 reset outputs");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R5 idle outputs");
    search("R8 key 00 after reset", 8'h00, 1'b0, 3'd0, 8'h00);

    write(3'd0, 8'h3C); write(3'd1, 8'hA5); write(3'd2, 8'h3C); write(3'd3, 8'h0F);
    write(3'd4, 8'hFF); write(3'd5, 8'h00); write(3'd6, 8'h81); write(3'd7, 8'h5A);

    foreach (VECS[i]) begin
      search(VECS[i].hit ? "R1 R6 table hit" : "R2 R3 R5 table miss",
             VECS[i].key, VECS[i].hit, VECS[i].addr, VECS[i].lines);
    end

    // R4: latency, then back-to-back requests
    @(negedge clk_i);
    srch_i = 1'b1; srch_key_i = 8'h81;
    @(negedge clk_i);
    srch_i = 1'b0;
    chk_idle("R4 no result one cycle after request");
    @(negedge clk_i);
    chk_res("R4 result two cycles after request", 1'b1, 3'd6, 8'h40);
    @(negedge clk_i);
    chk_idle("R4 single result cycle");
    srch_i = 1'b1; srch_key_i = 8'hA5;
    @(negedge clk_i);
    srch_key_i = 8'h81;
    @(negedge clk_i);
    srch_i = 1'b0;
    chk_res("R4 back-to-back first", 1'b1, 3'd1, 8'h02);
    @(negedge clk_i);
    chk_res("R4 back-to-back second", 1'b1, 3'd6, 8'h40);

    // R7: write in request cycle is seen
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd3; wr_data_i = 8'h77;
    srch_i = 1'b1; srch_key_i = 8'h77;
    @(negedge clk_i);
    wr_en_i = 1'b0; srch_i = 1'b0;
    @(negedge clk_i);
    chk_res("R7 same-cycle write seen", 1'b1, 3'd3, 8'h08);

    // R7: write in the cycle after the request is not seen
    @(negedge clk_i);
    srch_i = 1'b1; srch_key_i = 8'h66;
    @(negedge clk_i);
    srch_i = 1'b0;
    wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 8'h66;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk_res("R7 later write not seen", 1'b0, 3'd0, 8'h00);
    search("R7 later write visible next search", 8'h66, 1'b1, 3'd5, 8'h20);

    // R9: old values gone after rewrite
    search("R9 old 0F replaced", 8'h0F, 1'b0, 3'd0, 8'h00);
    search("R9 old 00 replaced", 8'h00, 1'b0, 3'd0, 8'h00);

    // R6: many matches, lowest reported
    for (int a = 2; a < 8; a++) write(3'(a), 8'hE7);
    search("R6 six matches", 8'hE7, 1'b1, 3'd2, 8'hFC);
    search("R6 entry 0 kept", 8'h3C, 1'b1, 3'd0, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule